// File: doc/BRIEF.md
# History Buffer Register Recovery

This block is a register file whose contents may be updated out of program order, paired with an undo log that lets an exception restore precise state. Each decoded instruction claims one log slot. The slot records the destination register index and the value that register held at that moment, read through an extra internal read port. Completing instructions write their results straight into the register file in whatever order they finish. Operand reads always come from the register file and from nowhere else.

Retirement is cheap. Committing the oldest instruction only frees its log slot and leaves the registers untouched. Recovery is slow by design. When an exception names the slot of a faulting instruction, the block walks the log backwards, one slot per cycle. It starts at the youngest slot and ends with the faulting slot included, writing each saved value back. While the walk runs, `busy` is high and decode is refused. When the walk ends, the next allocation reuses the faulting slot.

Top module: `history_regfile`

## Requirements
- R1: After reset every register reads 0, `busy` is low and the log is empty, so a decode request is accepted and gets tag 0.
- R2: Both read ports return the current contents of the addressed register combinationally.
- R3: An accepted writeback updates its register at the clock edge, independent of program order. The new value is visible on the read ports in the following cycle.
- R4: A decode request is accepted when all of these hold: the log is not full, `busy` is low, and no exception is raised in that cycle. Accepted decodes receive tags 0,1,…,7,0,… in order, counting from the slot after the last surviving one.
- R5: Once 8 slots are occupied, further decode requests are refused until a slot is freed.
- R6: A commit frees the oldest slot and leaves every register unchanged. A commit while the log is empty has no effect.
- R7: An exception whose tag names an occupied slot starts a walk in the next cycle. The walk holds `busy` high for exactly as many cycles as there are slots from the faulting one to the youngest, inclusive. Each cycle it restores one saved value, youngest first. Afterwards the registers equal the result of that sequential undo.
- R8: An exception whose tag names an unoccupied slot is ignored: `busy` stays low and the registers are unchanged.
- R9: Writebacks, commits and decode requests are ignored while `busy` is high.
- R10: After a walk, the next accepted decode receives the faulting slot's tag.
- R11: The value saved at decode is the destination's content before any writeback in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode allocation request |
| decDest | input | 4 | Destination register of the decoded instruction |
| decAccept | output | 1 | Request accepted this cycle |
| decTag | output | 3 | Slot tag given to the accepted instruction |
| wbValid | input | 1 | Result writeback strobe |
| wbReg | input | 4 | Writeback register index |
| wbData | input | 32 | Writeback value |
| rdAddrA | input | 4 | Read port A address |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B address |
| rdDataB | output | 32 | Read port B data |
| cmtValid | input | 1 | Retire the oldest slot |
| excValid | input | 1 | Exception request |
| excTag | input | 3 | Slot tag of the faulting instruction |
| busy | output | 1 | Undo walk in progress |

## Verification
The hardest state to reach is a walk over a log that has wrapped around and is completely full. In that case the faulting slot equals the head slot and the head and tail pointers coincide. Reaching it requires a long run of accepted decodes mixed with commits, followed by an exception tagged with the oldest slot. Random stimulus keeps the log near full with a low commit rate and picks exception tags anywhere among the occupied slots, including the oldest. A directed sequence also fills all eight slots and faults in the middle of them. During every walk the bench drives junk writebacks, commits and decodes, so that their absence from the restored state is observed.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  typedef struct packed {
    logic allocEn;
    logic wbEn;
    logic restoreEn;
  } hbrStrobe_t;
endpackage

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
  import hbr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     decValid,
  input  logic                     wbValid,
  input  logic                     cmtValid,
  input  logic                     excValid,
  input  logic [$clog2(DEPTH)-1:0] excTag,
  output logic                     decAccept,
  output logic [$clog2(DEPTH)-1:0] decTag,
  output logic                     busy,
  output hbrStrobe_t               strobe,
  output logic [$clog2(DEPTH)-1:0] allocIdx,
  output logic [$clog2(DEPTH)-1:0] restoreIdx
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  typedef enum logic {ST_IDLE, ST_WALK} walkState_t;

  walkState_t state;
  logic [PTR_W-1:0] headPtr, tailPtr, stopIdx, excOffset;
  logic [CNT_W-1:0] fill;
  logic walking, full, excHit, cmtDo;

  assign walking   = (state == ST_WALK);
  assign full      = (fill == CNT_W'(DEPTH));
  assign excOffset = excTag - headPtr;
  assign excHit    = excValid && !walking && ({1'b0, excOffset} < fill);
  assign decAccept = decValid && !full && !walking && !excValid;
  assign cmtDo     = cmtValid && (fill != '0) && !walking && !excValid;

  assign decTag     = tailPtr;
  assign allocIdx   = tailPtr;
  assign restoreIdx = tailPtr - PTR_W'(1);
  assign busy       = walking;

  always_comb begin
    strobe           = '0;
    strobe.allocEn   = decAccept;
    strobe.wbEn      = wbValid && !walking;
    strobe.restoreEn = walking;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      headPtr <= '0;
      tailPtr <= '0;
      stopIdx <= '0;
      fill    <= '0;
    end else if (walking) begin
      tailPtr <= restoreIdx;
      fill    <= fill - CNT_W'(1);
      if (restoreIdx == stopIdx) state <= ST_IDLE;
    end else if (excHit) begin
      state   <= ST_WALK;
      stopIdx <= excTag;
    end else begin
      if (decAccept) tailPtr <= tailPtr + PTR_W'(1);
      if (cmtDo)     headPtr <= headPtr + PTR_W'(1);
      fill <= fill + CNT_W'(decAccept) - CNT_W'(cmtDo);
    end
  end

  // counter bounding the walk length without deep $past
  logic [CNT_W:0] walkLen;
  always_ff @(posedge clk) begin
    if (!rst_n)       walkLen <= '0;
    else if (walking) walkLen <= walkLen + 1'b1;
    else              walkLen <= '0;
  end

  // R5
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !decAccept);
  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
  // R6
  empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |=> $stable(headPtr));
  // R7
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking |=> (tailPtr == ($past(tailPtr) - PTR_W'(1))));
  // R7
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walkLen <= (CNT_W+1)'(DEPTH));
  // R9
  walk_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> !decAccept);
endmodule

// File: rtl/hbr_datapath.sv
module hbr_datapath
  import hbr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  hbrStrobe_t                  strobe,
  input  logic [$clog2(DEPTH)-1:0]    allocIdx,
  input  logic [$clog2(DEPTH)-1:0]    restoreIdx,
  input  logic [$clog2(NUM_REGS)-1:0] decDest,
  input  logic [$clog2(NUM_REGS)-1:0] wbReg,
  input  logic [DATA_W-1:0]           wbData,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrA,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrB,
  output logic [DATA_W-1:0]           rdDataA,
  output logic [DATA_W-1:0]           rdDataB
);
  localparam int REG_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regArr  [NUM_REGS];
  logic [REG_W-1:0]  logReg  [DEPTH];
  logic [DATA_W-1:0] logVal  [DEPTH];
  logic [REG_W-1:0]  restoreReg;
  logic [DATA_W-1:0] restoreVal;
  logic [DATA_W-1:0] oldVal;

  assign restoreReg = logReg[restoreIdx];
  assign restoreVal = logVal[restoreIdx];
  assign oldVal     = regArr[decDest];  // extra read port for the undo log
  assign rdDataA    = regArr[rdAddrA];
  assign rdDataB    = regArr[rdAddrB];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regArr[g] <= '0;
      else if (strobe.restoreEn && (restoreReg == REG_W'(g)))
        regArr[g] <= restoreVal;
      else if (strobe.wbEn && (wbReg == REG_W'(g)))
        regArr[g] <= wbData;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        logReg[s] <= '0;
        logVal[s] <= '0;
      end else if (strobe.allocEn && (allocIdx == ($clog2(DEPTH))'(s))) begin
        logReg[s] <= decDest;
        logVal[s] <= oldVal;
      end
    end
  end

  // R9
  no_wb_during_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.restoreEn && strobe.wbEn));
  // R7
  restore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restoreEn |=> (regArr[$past(restoreReg)] == $past(restoreVal)));
  // R9
  no_alloc_during_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.restoreEn && strobe.allocEn));
endmodule

// File: rtl/history_regfile.sv
module history_regfile
  import hbr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        decValid,
  input  logic [$clog2(NUM_REGS)-1:0] decDest,
  output logic                        decAccept,
  output logic [$clog2(DEPTH)-1:0]    decTag,
  input  logic                        wbValid,
  input  logic [$clog2(NUM_REGS)-1:0] wbReg,
  input  logic [DATA_W-1:0]           wbData,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrA,
  output logic [DATA_W-1:0]           rdDataA,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrB,
  output logic [DATA_W-1:0]           rdDataB,
  input  logic                        cmtValid,
  input  logic                        excValid,
  input  logic [$clog2(DEPTH)-1:0]    excTag,
  output logic                        busy
);
  hbrStrobe_t strobe;
  logic [$clog2(DEPTH)-1:0] allocIdx, restoreIdx;

  hbr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .wbValid(wbValid),
    .cmtValid(cmtValid), .excValid(excValid), .excTag(excTag),
    .decAccept(decAccept), .decTag(decTag), .busy(busy), .strobe(strobe),
    .allocIdx(allocIdx), .restoreIdx(restoreIdx)
  );

  hbr_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .allocIdx(allocIdx),
    .restoreIdx(restoreIdx), .decDest(decDest), .wbReg(wbReg), .wbData(wbData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: tb/history_regfile_tb.sv
`timescale 1ns/1ps
module history_regfile_tb;
  logic clk = 0;
  logic rst_n;
  logic decValid, wbValid, cmtValid, excValid;
  logic [3:0] decDest, wbReg, rdAddrA, rdAddrB;
  logic [31:0] wbData, rdDataA, rdDataB;
  logic [2:0] excTag, decTag;
  logic decAccept, busy;

  int checks = 0, errors = 0;
  logic [31:0] mRf [16];
  logic [3:0]  mLogReg [8];
  logic [31:0] mLogVal [8];
  int mHead, mTail, mCount;

  always #2 clk = ~clk;

  history_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decDest(decDest),
    .decAccept(decAccept), .decTag(decTag), .wbValid(wbValid), .wbReg(wbReg),
    .wbData(wbData), .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB),
    .rdDataB(rdDataB), .cmtValid(cmtValid), .excValid(excValid),
    .excTag(excTag), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    decValid = 0; wbValid = 0; cmtValid = 0; excValid = 0;
  endtask

  task automatic compareRegs(input string req);
    for (int i = 0; i < 16; i++) begin
      rdAddrA = 4'(i); rdAddrB = 4'(15 - i);
      #0.05;
      chk(rdDataA === mRf[i], req, "reg via port A", rdDataA, mRf[i]);
      chk(rdDataB === mRf[15-i], req, "reg via port B", rdDataB, mRf[15-i]);
    end
    tick();
  endtask

  // one normal cycle: drive, check acceptance, update model, clock
  task automatic doCycle(input bit dv, input logic [3:0] dest, input bit wv,
                         input logic [3:0] wr, input logic [31:0] wd, input bit cv);
    bit expAcc;
    decValid = dv; decDest = dest; wbValid = wv; wbReg = wr; wbData = wd;
    cmtValid = cv; excValid = 0;
    #0.5;
    expAcc = dv && (mCount < 8);
    chk(decAccept === expAcc, "R4/R5", "decAccept", 32'(decAccept), 32'(expAcc));
    if (expAcc)
      chk(decTag === 3'(mTail), "R4", "decTag", 32'(decTag), 32'(mTail));
    if (expAcc) begin  // R11: old value sampled before same-cycle writeback
      mLogReg[mTail] = dest;
      mLogVal[mTail] = mRf[dest];
      mTail = (mTail + 1) % 8;
    end
    if (wv) mRf[wr] = wd;
    if (cv && mCount > 0) begin
      mHead = (mHead + 1) % 8;
      mCount--;
    end
    if (expAcc) mCount++;
    tick();
    idle();
  endtask

  task automatic doExc(input logic [2:0] tag);
    int off, n, cycles;
    bit hit;
    off = (int'(tag) - mHead + 8) % 8;
    hit = off < mCount;
    excValid = 1; excTag = tag; decValid = 1; decDest = 4'd1;
    #0.5;
    chk(decAccept === 1'b0, "R4", "decode during exception", 32'(decAccept), 0);
    tick();
    idle();
    if (hit) begin
      n = mCount - off;
      cycles = 0;
      while (busy === 1'b1 && cycles < 20) begin
        // R9: junk traffic during the walk must be ignored
        wbValid = 1; wbReg = 4'($urandom); wbData = $urandom;
        cmtValid = 1; decValid = 1;
        #0.5;
        chk(decAccept === 1'b0, "R9", "decode during walk", 32'(decAccept), 0);
        tick();
        cycles++;
      end
      idle();
      chk(cycles == n, "R7", "walk length", 32'(cycles), 32'(n));
      for (int i = 0; i < n; i++) begin
        int idx = (mTail - 1 - i + 8) % 8;
        mRf[mLogReg[idx]] = mLogVal[idx];
      end
      mTail = int'(tag);
      mCount = off;
      compareRegs("R7/R9");
      decValid = 1; decDest = 4'd0;
      #0.5;
      chk(decAccept === 1'b1 && decTag === tag, "R10", "tag after walk",
          32'(decTag), 32'(tag));
      idle();
    end else begin
      chk(busy === 1'b0, "R8", "busy after unoccupied tag", 32'(busy), 0);
      compareRegs("R8");
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    idle();
    decDest = 0; wbReg = 0; wbData = 0; rdAddrA = 0; rdAddrB = 0; excTag = 0;
    rst_n = 0;
    for (int i = 0; i < 16; i++) mRf[i] = 0;
    for (int i = 0; i < 8; i++) begin mLogReg[i] = 0; mLogVal[i] = 0; end
    mHead = 0; mTail = 0; mCount = 0;
    tick(); tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
    decValid = 1; decDest = 0;
    #0.5;
    chk(decAccept === 1'b1 && decTag === 3'd0, "R1", "first decode", 32'(decTag), 0);
    idle();
    compareRegs("R1");

    // R2/R3 out-of-order writebacks become visible on read ports
    doCycle(0, 0, 1, 4'd5, 32'hAAAA0005, 0);
    doCycle(0, 0, 1, 4'd3, 32'hBBBB0003, 0);
    compareRegs("R2/R3");

    // R11 decode and writeback to the same register in one cycle
    doCycle(1, 4'd5, 1, 4'd5, 32'h55550000, 0);
    // R4/R5 fill the log; the ninth request must be refused
    for (int i = 1; i < 8; i++) doCycle(1, 4'(i + 2), 1, 4'(i), 32'h1000 + 32'(i), 0);
    doCycle(1, 4'd2, 0, 0, 0, 0);
    // R6 commit frees a slot but touches no register
    doCycle(0, 0, 0, 0, 0, 1);
    compareRegs("R6");
    doCycle(1, 4'd9, 1, 4'd9, 32'h99, 0);
    // writes by the surviving instructions, then fault in the middle
    for (int i = 0; i < 8; i++) doCycle(0, 0, 1, 4'(i + 2), 32'h7000 + 32'(i), 0);
    doExc(3'd4);

    // R6 drain fully, extra commits on an empty log do nothing
    for (int i = 0; i < 10; i++) doCycle(0, 0, 0, 0, 0, 1);
    compareRegs("R6");
    doExc(3'd2);  // R8 empty log
    // full, wrapped log faulting at the oldest slot
    for (int i = 0; i < 9; i++) doCycle(1, 4'(i), 1, 4'(15 - i), $urandom, 0);
    doExc(3'(mHead));

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int r = int'($urandom % 100);
      if (r < 5) begin
        if (mCount > 0 && r != 0)
          doExc(3'((mHead + int'($urandom % 32'(mCount))) % 8));
        else
          doExc(3'($urandom));
      end else begin
        doCycle(($urandom % 3) != 0, 4'($urandom), ($urandom % 2) == 1,
                4'($urandom), $urandom, ($urandom % 4) == 0);
      end
      if (it % 200 == 0) compareRegs("R3");
    end
    compareRegs("R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule